// File: doc/BRIEF.md
# Lockable Two-Stage Watchdog Timer

This block is a watchdog timer on a small 32-bit register bus. The bus carries an address, a write strobe, write data and combinational read data. Software loads a reload value, enables the counter and then kicks it at intervals by writing the clear address. A write to that address clears the pending interrupt and restarts the countdown.

When the countdown runs out the first time, the interrupt output goes high. If the countdown runs out a second time while that interrupt is still set, and the reset enable is on, the block drives a system reset. That reset is a level, and it holds until the block's own reset input is applied. A fixed prescaler divides the bus clock by 16 before the counter sees it.

A lock register guards every other register against stray writes. Only one exact key value opens it, and any other value written there closes it again. Reset is asynchronous and active low, and its release is synchronised inside the block.

Top module: `twostage_wdt`

## Requirements
- R1: After reset the block is locked: a read of address 0xC00 returns 1, the load and control registers read 0, and `irq_o` and `sys_rst_o` are low. A write of 0x1ACCE551 to 0xC00 makes that address read 0 (unlocked). A write of any other value to 0xC00 makes it read 1. Writes to 0xC00 are accepted in either state.
- R2: While locked, writes to 0x000 (load), 0x008 (control) and 0x00C (clear) change no register, no counter and no output.
- R3: The counter moves one step for every 16 clock cycles while control bit 0 is set. A control write that turns bit 0 on copies the load value into the counter. With load value L, the first expiry is visible 16*(L+1) cycles after that control write.
- R4: An expiry is a prescaled step taken while the counter is zero. It sets the pending interrupt and copies the load value back into the counter. `irq_o` is the pending flag ANDed with control bit 0.
- R5: An expiry that finds the interrupt already pending, with control bit 1 set, raises `sys_rst_o`. With bit 1 clear, no reset is produced.
- R6: Once `sys_rst_o` is high, it stays high until `rst_n` is asserted.
- R7: Any unlocked write to 0x00C clears the pending interrupt and copies the load value into the counter. If it lands in the same cycle as an expiry, the clear wins: the interrupt ends low and no reset is raised.
- R8: An unlocked write to 0x000 stores the value and puts it into the counter at once. A load value of 0 expires on the next prescaled step (16 cycles after enabling).
- R9: Writing 0 to control stops the prescaler and the counter, so no further expiry happens, and `irq_o` is forced low.
- R10: Read data is the load value at 0x000, the control bits in bits 1:0 at 0x008, the lock state at 0xC00, and 0 at any other address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and counter clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Interrupt level after the first expiry |
| sys_rst_o | output | 1 | Sticky system reset after an unserviced second expiry |

## Verification
The kick and the second expiry can fall in the same clock edge, and which one wins decides between a quiet restart and a system reset. The bench arms the timer with both enables set, lets the first expiry raise the interrupt, and then sweeps the kick across a window of cycles that straddles the second expiry edge. A cycle-accurate behavioural model in the bench gives clear-over-expiry priority and compares `irq_o`, `sys_rst_o` and read data on every cycle, so the colliding edge is judged like every other edge. A separate sweep also makes load writes and relocking fall among running ticks.

// File: rtl/twd_pkg.sv
package twd_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam int unsigned DATA_W = 32;

  localparam logic [ADDR_W-1:0] OFS_LOAD = 12'h000;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 12'h008;
  localparam logic [ADDR_W-1:0] OFS_KICK = 12'h00C;
  localparam logic [ADDR_W-1:0] OFS_LOCK = 12'hC00;

  localparam logic [DATA_W-1:0] UNLOCK_KEY = 32'h1ACCE551;

  typedef struct packed {
    logic rst_en;   // bit 1
    logic run_en;   // bit 0
  } ctrl_t;
endpackage

// File: rtl/twd_regs.sv
module twd_regs
  import twd_pkg::*;
#(
  parameter int unsigned CNT_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [CNT_W-1:0]    load_q,
  output ctrl_t               ctrl_q,
  output logic                locked_q,
  output logic                kick_o,
  output logic                reload_o,
  output logic [CNT_W-1:0]    reload_val_o
);
  logic             wr_open;
  logic             hit_load, hit_ctrl, hit_kick, hit_lock;
  logic [CNT_W-1:0] load_d;
  ctrl_t            ctrl_d;
  logic             locked_d;
  logic             start;

  assign hit_load = (bus_addr == OFS_LOAD);
  assign hit_ctrl = (bus_addr == OFS_CTRL);
  assign hit_kick = (bus_addr == OFS_KICK);
  assign hit_lock = (bus_addr == OFS_LOCK);
  assign wr_open  = bus_we && !locked_q;

  // next-state
  always_comb begin
    load_d   = load_q;
    ctrl_d   = ctrl_q;
    locked_d = locked_q;
    if (bus_we && hit_lock) locked_d = (bus_wdata != UNLOCK_KEY);
    if (wr_open && hit_load) load_d = bus_wdata[CNT_W-1:0];
    if (wr_open && hit_ctrl) ctrl_d = ctrl_t'(bus_wdata[1:0]);
  end

  assign start  = wr_open && hit_ctrl && bus_wdata[0] && !ctrl_q.run_en;
  assign kick_o = wr_open && hit_kick;

  always_comb begin
    reload_o     = 1'b0;
    reload_val_o = load_q;
    if (wr_open && hit_load) begin
      reload_o     = 1'b1;
      reload_val_o = bus_wdata[CNT_W-1:0];
    end else if (kick_o || start) begin
      reload_o     = 1'b1;
    end
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q   <= '0;
      ctrl_q   <= '0;
      locked_q <= 1'b1;
    end else begin
      load_q   <= load_d;
      ctrl_q   <= ctrl_d;
      locked_q <= locked_d;
    end
  end

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (hit_load)      bus_rdata[CNT_W-1:0] = load_q;
    else if (hit_ctrl) bus_rdata[1:0]       = ctrl_q;
    else if (hit_lock) bus_rdata[0]         = locked_q;
  end

  // R2: a locked write leaves load and control untouched
  p_locked_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && locked_q && !hit_lock) |=> ($stable(load_q) && $stable(ctrl_q)));

  // R1: lock state after a lock write follows the key comparison
  p_lock_key_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && hit_lock && bus_wdata == UNLOCK_KEY) |=> !locked_q);
endmodule

// File: rtl/twd_prescale.sv
module twd_prescale #(
  parameter int unsigned DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  generate
    if (DIV > 1) begin : g_div
      localparam int unsigned PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pre_q, pre_d;

      always_comb begin
        if (!run_i)            pre_d = '0;
        else if (pre_q == LAST) pre_d = '0;
        else                   pre_d = pre_q + 1'b1;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
      end

      assign tick_o = run_i && (pre_q == LAST);

      // R3: steps are never on consecutive cycles
      p_tick_spacing_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    end else begin : g_nodiv
      assign tick_o = run_i;
    end
  endgenerate
endmodule

// File: rtl/twd_core.sv
module twd_core #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] reload_val_i,
  input  logic             kick_i,
  input  logic             rst_en_i,
  input  logic [CNT_W-1:0] load_i,
  output logic             irq_q,
  output logic             sys_rst_q
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             irq_d, sys_rst_d;
  logic             expire;

  assign expire = tick_i && !reload_i && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (reload_i)    cnt_d = reload_val_i;
    else if (expire) cnt_d = load_i;
    else if (tick_i) cnt_d = cnt_q - 1'b1;
  end

  always_comb begin
    irq_d     = irq_q;
    sys_rst_d = sys_rst_q;
    if (kick_i)      irq_d = 1'b0;
    else if (expire) irq_d = 1'b1;
    if (expire && irq_q && rst_en_i) sys_rst_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q     <= '0;
      irq_q     <= 1'b0;
      sys_rst_q <= 1'b0;
    end else begin
      cnt_q     <= cnt_d;
      irq_q     <= irq_d;
      sys_rst_q <= sys_rst_d;
    end
  end

  // R5: reset rises only if the interrupt was pending and reset enabled
  p_rst_needs_irq_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst_q) |-> $past(irq_q && rst_en_i));

  // R6: reset output is sticky
  p_rst_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_q |=> sys_rst_q);

  // R7: a kick always leaves the interrupt clear
  p_kick_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    kick_i |=> !irq_q);

  // R4: interrupt only rises on a prescaled step
  p_irq_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> $past(tick_i));
endmodule

// File: rtl/twostage_wdt.sv
module twostage_wdt
  import twd_pkg::*;
#(
  parameter int unsigned CNT_W   = 32,
  parameter int unsigned PRE_DIV = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic                irq_o,
  output logic                sys_rst_o
);
  logic             sync1_q, rst_int_n;
  logic [CNT_W-1:0] load_q, reload_val;
  ctrl_t            ctrl_q;
  logic             locked_q, kick, reload, tick, irq_q;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q   <= 1'b0;
      rst_int_n <= 1'b0;
    end else begin
      sync1_q   <= 1'b1;
      rst_int_n <= sync1_q;
    end
  end

  twd_regs #(.CNT_W(CNT_W)) i_regs (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .bus_addr     (bus_addr),
    .bus_we       (bus_we),
    .bus_wdata    (bus_wdata),
    .bus_rdata    (bus_rdata),
    .load_q       (load_q),
    .ctrl_q       (ctrl_q),
    .locked_q     (locked_q),
    .kick_o       (kick),
    .reload_o     (reload),
    .reload_val_o (reload_val)
  );

  twd_prescale #(.DIV(PRE_DIV)) i_pre (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .run_i  (ctrl_q.run_en),
    .tick_o (tick)
  );

  twd_core #(.CNT_W(CNT_W)) i_core (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .tick_i       (tick),
    .reload_i     (reload),
    .reload_val_i (reload_val),
    .kick_i       (kick),
    .rst_en_i     (ctrl_q.rst_en),
    .load_i       (load_q),
    .irq_q        (irq_q),
    .sys_rst_q    (sys_rst_o)
  );

  assign irq_o = irq_q && ctrl_q.run_en;

  // R9: with the counter stopped the interrupt output is low
  p_stopped_quiet_r9: assert property (@(posedge clk) disable iff (!rst_int_n)
    !ctrl_q.run_en |-> !irq_o);
endmodule

// File: tb/test_twostage_wdt.sv
`timescale 1ns/1ps
module test_twostage_wdt;
  localparam logic [11:0] A_LOAD = 12'h000, A_CTRL = 12'h008,
                          A_KICK = 12'h00C, A_LOCK = 12'hC00;
  localparam logic [31:0] KEY = 32'h1ACCE551;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = 12'h000;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq_o, sys_rst_o;

  int n_tests = 0, n_fail = 0;
  bit cmp_on = 1'b0, done = 1'b0;
  string cur_req = "R1";

  // behavioural reference state
  logic [31:0] m_load, m_cnt;
  logic [1:0]  m_ctrl;
  int          m_pre;
  bit          m_locked, m_irq, m_rst;

  always #2 clk = ~clk;

  twostage_wdt i_twostage_wdt (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
    .sys_rst_o(sys_rst_o));

  task automatic m_clear();
    m_load = '0; m_cnt = '0; m_ctrl = '0; m_pre = 0;
    m_locked = 1'b1; m_irq = 1'b0; m_rst = 1'b0;
  endtask

  initial m_clear();
  always @(negedge rst_n) m_clear();

  // model step at each rising edge
  always @(posedge clk) begin
    if (rst_n) begin
      bit tick, reload, kick, expire;
      logic [31:0] rval;
      tick = m_ctrl[0] && (m_pre == 15);
      reload = 1'b0; kick = 1'b0; rval = m_load;
      if (bus_we && bus_addr == A_LOCK) m_locked = (bus_wdata != KEY);
      else if (bus_we && !m_locked) begin
        if (bus_addr == A_LOAD) begin
          reload = 1'b1; rval = bus_wdata;
        end else if (bus_addr == A_KICK) begin
          kick = 1'b1; reload = 1'b1;
        end else if (bus_addr == A_CTRL && bus_wdata[0] && !m_ctrl[0]) begin
          reload = 1'b1;
        end
      end
      expire = tick && !reload && (m_cnt == 0);
      if (expire && m_irq && m_ctrl[1]) m_rst = 1'b1;
      if (kick) m_irq = 1'b0;
      else if (expire) m_irq = 1'b1;
      if (reload) m_cnt = rval;
      else if (expire) m_cnt = m_load;
      else if (tick) m_cnt = m_cnt - 1;
      m_pre = m_ctrl[0] ? (m_pre + 1) % 16 : 0;
      if (bus_we && !m_locked && bus_addr == A_LOAD) m_load = bus_wdata;
      if (bus_we && !(bus_addr == A_LOCK) && bus_addr == A_CTRL && !m_locked)
        m_ctrl = bus_wdata[1:0];
    end
  end

  function automatic logic [31:0] m_rdata(logic [11:0] a);
    case (a)
      A_LOAD:  return m_load;
      A_CTRL:  return {30'b0, m_ctrl};
      A_LOCK:  return {31'b0, m_locked};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0t actual=%h expected=%h", req, $time, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (cmp_on && !done) begin
      chk({cur_req, " irq"},  {31'b0, irq_o},     {31'b0, m_irq && m_ctrl[0]});
      chk({cur_req, " rst"},  {31'b0, sys_rst_o}, {31'b0, m_rst});
      chk({cur_req, " rdat"}, bus_rdata,          m_rdata(bus_addr));
    end
  end

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk); #1;
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk); #1;
    bus_we = 1'b0;
  endtask

  task automatic rd(string req, logic [11:0] a, logic [31:0] exp);
    @(negedge clk); #1;
    bus_addr = a;
    @(negedge clk);
    chk(req, bus_rdata, exp);
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk); #1;
    rst_n = 1'b0; bus_we = 1'b0;
    idle(2); #1;
    rst_n = 1'b1;
    idle(4);
  endtask

  task automatic wait_irq(output int n);
    n = 0;
    while (!irq_o && n < 2000) begin
      @(negedge clk); n++;
    end
  endtask

  initial begin
    int n;
    idle(3); #1;
    rst_n = 1'b1;
    cmp_on = 1'b1;
    idle(4);

    // R1 reset state
    cur_req = "R1";
    rd("R1 lock", A_LOCK, 32'd1);
    rd("R1 load", A_LOAD, 32'd0);
    chk("R1 rst", {31'b0, sys_rst_o}, 32'd0);

    // R2 locked writes ignored
    cur_req = "R2";
    wr(A_LOAD, 32'd7);
    wr(A_CTRL, 32'd3);
    idle(40);
    rd("R2 load", A_LOAD, 32'd0);
    rd("R2 ctrl", A_CTRL, 32'd0);

    // R1 unlock / R10 read map
    cur_req = "R10";
    wr(A_LOCK, KEY);
    rd("R1 unlocked", A_LOCK, 32'd0);
    wr(A_LOAD, 32'd3);
    rd("R10 load", A_LOAD, 32'd3);
    rd("R10 other", 12'h004, 32'd0);

    // R3/R4 first expiry timing, interrupt only
    cur_req = "R3";
    wr(A_CTRL, 32'd1);
    wait_irq(n);
    chk("R3 period", n, 32'd64);
    cur_req = "R4";
    idle(80);
    chk("R4 irq held", {31'b0, irq_o}, 32'd1);
    chk("R5 no rst without enable", {31'b0, sys_rst_o}, 32'd0);

    // R7 kick clears
    cur_req = "R7";
    wr(A_KICK, 32'd0);
    chk("R7 cleared", {31'b0, irq_o}, 32'd0);

    // R2 relock then kick ignored
    cur_req = "R2";
    idle(70);
    wr(A_LOCK, 32'd1);
    wr(A_KICK, 32'd0);
    chk("R2 kick ignored", {31'b0, irq_o}, 32'd1);

    // R9 stop
    cur_req = "R9";
    wr(A_LOCK, KEY);
    wr(A_CTRL, 32'd0);
    idle(200);
    chk("R9 stopped", {31'b0, irq_o}, 32'd0);

    // R5/R6 unserviced second expiry
    cur_req = "R5";
    do_reset();
    wr(A_LOCK, KEY);
    wr(A_LOAD, 32'd1);
    wr(A_CTRL, 32'd3);
    idle(100);
    chk("R5 rst", {31'b0, sys_rst_o}, 32'd1);
    cur_req = "R6";
    wr(A_KICK, 32'd0);
    wr(A_CTRL, 32'd0);
    idle(50);
    chk("R6 sticky", {31'b0, sys_rst_o}, 32'd1);
    do_reset();
    chk("R6 released", {31'b0, sys_rst_o}, 32'd0);

    // R8 load zero
    cur_req = "R8";
    wr(A_LOCK, KEY);
    wr(A_LOAD, 32'd0);
    wr(A_CTRL, 32'd1);
    wait_irq(n);
    chk("R8 zero load", n, 32'd16);

    // R7 kick swept across the second expiry
    cur_req = "R7";
    for (int off = 0; off < 12; off++) begin
      do_reset();
      wr(A_LOCK, KEY);
      wr(A_LOAD, 32'd1);
      wr(A_CTRL, 32'd3);
      idle(56 + off);
      wr(A_KICK, 32'd0);
      idle(8);
    end

    // R8 load writes sprinkled over running ticks
    cur_req = "R8";
    for (int k = 0; k < 10; k++) begin
      do_reset();
      wr(A_LOCK, KEY);
      wr(A_LOAD, 32'd2);
      wr(A_CTRL, 32'd1);
      idle(20 + 3 * k);
      wr(A_LOAD, 32'(k % 3));
      idle(30);
      wr(A_KICK, 32'd0);
      idle(40);
    end

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule